// File: doc/BRIEF.md
# Pipelined Parallel System-Throughput Evaluator

This block scores candidate pairings of transmit antennas and users for a downlink scheduler. Every clock it can take one combination: for each antenna, a bit saying whether it transmits and the index of the user it serves. One calculation lane per antenna works on that combination at the same time. Each lane forms its user's signal-to-interference-plus-noise ratio from a table of channel gains, maps it to a rate through a threshold table, and a registered adder tree sums the lane rates. The total comes out a fixed number of cycles later, together with a tag supplied by the caller.

Software loads the channel gains, the noise constant, the rate thresholds and the rates through a single write port while no combinations are in flight. A search engine outside this block then streams combinations in back to back and keeps whichever total is best. Because no state passes from one combination to the next, throughput is one evaluation per cycle regardless of the pattern.

Top module: `tput_eval`

## Requirements
- R1: With `inValid` high at a rising edge, `outValid` is high exactly LAT = 2 + log2(NUM_ANT) edges later (4 by default) with `outTag` equal to the `inTag` sampled with it; one combination is accepted every cycle, and `inActive`/`inUe` are ignored while `inValid` is low.
- R2: For antenna a serving user u (`inUe` bits [a*UE_W +: UE_W]), the signal is gain(a,u) and the denominator is the noise constant plus gain(b,u) summed over every other transmitting antenna b, including antennas serving the same user.
- R3: A lane's rate is the rate of the highest-indexed level k whose threshold t satisfies signal*2^THR_FRAC >= t*denominator (equality counts as met, thresholds in units of 2^-THR_FRAC, loaded in non-decreasing order); if no level is met the rate is 0.
- R4: A blank antenna (`inActive` bit a = 0) adds nothing to any denominator and its lane adds 0; a combination with all antennas blank totals 0.
- R5: `outTotal` is the exact sum of the lane rates, RATE_W + log2(NUM_ANT) bits wide, so NUM_ANT lanes at the maximum rate do not overflow.
- R6: A write with `cfgWe` high stores `cfgData` according to `cfgSel`: 0 writes gain(antenna = `cfgIdx`[UE_W +: ANT_W], user = `cfgIdx`[UE_W-1:0]), 1 writes the noise constant, 2 writes threshold level `cfgIdx`[LVL_W-1:0], 3 writes the rate of that level.
- R7: After reset and in every cycle where `outValid` is low, `outValid` and `outTotal` read 0; reset clears all tables to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 2 | Table select: 0 gain, 1 noise, 2 threshold, 3 rate |
| cfgIdx | input | IDX_W | Table index (antenna/user or level) |
| cfgData | input | CFG_W | Value written |
| inValid | input | 1 | A combination is presented this cycle |
| inTag | input | TAG_W | Caller tag carried with the combination |
| inActive | input | NUM_ANT | Bit a set: antenna a transmits |
| inUe | input | NUM_ANT*UE_W | Served user index per antenna |
| outValid | output | 1 | A total is presented this cycle |
| outTag | output | TAG_W | Tag of the presented total |
| outTotal | output | SUM_W | System throughput of the combination |

## Verification
The hardest cases to reach are the exact threshold boundary and the widest possible total: the first needs a signal and denominator whose scaled product lands precisely on a threshold, and the second needs every lane at the top rate, which random gains almost never produce. The bench reprograms individual gains and the noise constant between combinations so that signal*4 equals threshold*denominator exactly, falls one step short, and lands below the lowest level; it then zeroes the cross gains and the noise and loads the largest rate so that all lanes saturate together. A stream of pseudo-random combinations sent on consecutive cycles, with junk on the data inputs in idle cycles, covers the one-per-cycle rate, tag order and valid gating.

// File: rtl/tput_pkg.sv
package tput_pkg;

  // Table selector on the configuration port
  typedef enum logic [1:0] {
    CFG_GAIN  = 2'd0,
    CFG_NOISE = 2'd1,
    CFG_THR   = 2'd2,
    CFG_RATE  = 2'd3
  } cfgSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic gainWr;
    logic noiseWr;
    logic thrWr;
    logic rateWr;
    logic sigAdv;   // load the signal/denominator stage
    logic rateAdv;  // load the rate-selection stage
  } ctlStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tput_ctl.sv
module tput_ctl
  import tput_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int LAT   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgSel,
  input  logic             inValid,
  input  logic [TAG_W-1:0] inTag,
  output ctlStrobe_t       strb,
  output logic             outValid,
  output logic [TAG_W-1:0] outTag
);

  logic [LAT-1:0]            vPipe;
  logic [LAT-1:0][TAG_W-1:0] tagPipe;

  always_comb begin
    strb.gainWr  = cfgWe && (cfgSel == CFG_GAIN);
    strb.noiseWr = cfgWe && (cfgSel == CFG_NOISE);
    strb.thrWr   = cfgWe && (cfgSel == CFG_THR);
    strb.rateWr  = cfgWe && (cfgSel == CFG_RATE);
    strb.sigAdv  = inValid;
    strb.rateAdv = vPipe[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vPipe   <= '0;
      tagPipe <= '0;
    end else begin
      vPipe   <= {vPipe[LAT-2:0], inValid};
      tagPipe <= {tagPipe[LAT-2:0], inTag};
    end
  end

  assign outValid = vPipe[LAT-1];
  assign outTag   = tagPipe[LAT-1];

endmodule

// File: rtl/tput_lane.sv
module tput_lane #(
  parameter int LANE     = 0,
  parameter int NUM_ANT  = 4,
  parameter int NUM_UE   = 8,
  parameter int GAIN_W   = 8,
  parameter int THR_W    = 8,
  parameter int THR_FRAC = 2,
  parameter int RATE_W   = 8,
  parameter int NUM_LVL  = 4,
  parameter int ANT_W    = $clog2(NUM_ANT),
  parameter int UE_W     = $clog2(NUM_UE)
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   sigAdv,
  input  logic                                   rateAdv,
  input  logic [NUM_ANT-1:0]                     active,
  input  logic [NUM_ANT-1:0][UE_W-1:0]           ueSel,
  input  logic [NUM_ANT-1:0][NUM_UE-1:0][GAIN_W-1:0] gainTbl,
  input  logic [GAIN_W-1:0]                      noise,
  input  logic [NUM_LVL-1:0][THR_W-1:0]          thrTbl,
  input  logic [NUM_LVL-1:0][RATE_W-1:0]         rateTbl,
  output logic [RATE_W-1:0]                      laneRate
);

  localparam int DEN_W  = GAIN_W + ANT_W;
  localparam int PROD_W = THR_W + DEN_W;

  logic [UE_W-1:0]   servedUe;
  logic [GAIN_W-1:0] sigNext, sigQ;
  logic [DEN_W-1:0]  denNext, denQ;
  logic              actQ;

  // Stage 1: signal and interference-plus-noise
  always_comb begin
    servedUe = ueSel[LANE];
    sigNext  = active[LANE] ? gainTbl[LANE][servedUe] : '0;
    denNext  = DEN_W'(noise);
    for (int b = 0; b < NUM_ANT; b++) begin
      if (b != LANE && active[b])
        denNext = denNext + DEN_W'(gainTbl[b][servedUe]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigQ <= '0;
      denQ <= '0;
      actQ <= 1'b0;
    end else if (sigAdv) begin
      sigQ <= sigNext;
      denQ <= denNext;
      actQ <= active[LANE];
    end
  end

  // Stage 2: divider-free ratio-to-rate mapping
  logic [PROD_W-1:0] sigScaled;
  logic [PROD_W-1:0] prod;
  logic [RATE_W-1:0] pick;

  always_comb begin
    sigScaled = PROD_W'(sigQ) << THR_FRAC;
    prod      = '0;
    pick      = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      prod = PROD_W'(thrTbl[k]) * PROD_W'(denQ);
      if (sigScaled >= prod)
        pick = rateTbl[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      laneRate <= '0;
    else if (rateAdv)
      laneRate <= actQ ? pick : '0;
  end

endmodule

// File: rtl/tput_sumtree.sv
module tput_sumtree #(
  parameter int N     = 4,
  parameter int IN_W  = 8,
  parameter int LVLS  = $clog2(N),
  parameter int OUT_W = IN_W + LVLS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [N-1:0][IN_W-1:0]  leaves,
  output logic [OUT_W-1:0]        sum
);

  genvar l;
  for (l = 0; l < LVLS; l++) begin : lvl
    localparam int CNT = N >> (l + 1);
    logic [OUT_W-1:0] node [CNT];

    if (l == 0) begin : leafLvl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int j = 0; j < CNT; j++) node[j] <= '0;
        end else begin
          for (int j = 0; j < CNT; j++)
            node[j] <= OUT_W'(leaves[2*j]) + OUT_W'(leaves[2*j+1]);
        end
      end
    end else begin : innerLvl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int j = 0; j < CNT; j++) node[j] <= '0;
        end else begin
          for (int j = 0; j < CNT; j++)
            node[j] <= lvl[l-1].node[2*j] + lvl[l-1].node[2*j+1];
        end
      end
    end
  end

  assign sum = lvl[LVLS-1].node[0];

endmodule

// File: rtl/tput_dp.sv
module tput_dp
  import tput_pkg::*;
#(
  parameter int NUM_ANT  = 4,
  parameter int NUM_UE   = 8,
  parameter int GAIN_W   = 8,
  parameter int THR_W    = 8,
  parameter int THR_FRAC = 2,
  parameter int RATE_W   = 8,
  parameter int NUM_LVL  = 4,
  parameter int ANT_W    = 2,
  parameter int UE_W     = 3,
  parameter int LVL_W    = 2,
  parameter int IDX_W    = 5,
  parameter int CFG_W    = 8,
  parameter int SUM_W    = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strb,
  input  logic [IDX_W-1:0]          cfgIdx,
  input  logic [CFG_W-1:0]          cfgData,
  input  logic [NUM_ANT-1:0]        inActive,
  input  logic [NUM_ANT*UE_W-1:0]   inUe,
  output logic [SUM_W-1:0]          total
);

  logic [NUM_ANT-1:0][NUM_UE-1:0][GAIN_W-1:0] gainTbl;
  logic [GAIN_W-1:0]                          noise;
  logic [NUM_LVL-1:0][THR_W-1:0]              thrTbl;
  logic [NUM_LVL-1:0][RATE_W-1:0]             rateTbl;

  logic [UE_W-1:0]  cfgUe;
  logic [ANT_W-1:0] cfgAnt;
  logic [LVL_W-1:0] cfgLvl;

  assign cfgUe  = cfgIdx[UE_W-1:0];
  assign cfgAnt = cfgIdx[UE_W +: ANT_W];
  assign cfgLvl = cfgIdx[LVL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainTbl <= '0;
      noise   <= '0;
      thrTbl  <= '0;
      rateTbl <= '0;
    end else begin
      if (strb.gainWr)  gainTbl[cfgAnt][cfgUe] <= cfgData[GAIN_W-1:0];
      if (strb.noiseWr) noise                  <= cfgData[GAIN_W-1:0];
      if (strb.thrWr)   thrTbl[cfgLvl]         <= cfgData[THR_W-1:0];
      if (strb.rateWr)  rateTbl[cfgLvl]        <= cfgData[RATE_W-1:0];
    end
  end

  logic [NUM_ANT-1:0][UE_W-1:0]   ueSel;
  logic [NUM_ANT-1:0][RATE_W-1:0] laneRate;

  assign ueSel = inUe;

  genvar a;
  for (a = 0; a < NUM_ANT; a++) begin : lane
    tput_lane #(
      .LANE(a), .NUM_ANT(NUM_ANT), .NUM_UE(NUM_UE), .GAIN_W(GAIN_W),
      .THR_W(THR_W), .THR_FRAC(THR_FRAC), .RATE_W(RATE_W),
      .NUM_LVL(NUM_LVL), .ANT_W(ANT_W), .UE_W(UE_W)
    ) u_lane (
      .clk(clk), .rstN(rstN),
      .sigAdv(strb.sigAdv), .rateAdv(strb.rateAdv),
      .active(inActive), .ueSel(ueSel),
      .gainTbl(gainTbl), .noise(noise),
      .thrTbl(thrTbl), .rateTbl(rateTbl),
      .laneRate(laneRate[a])
    );
  end

  tput_sumtree #(
    .N(NUM_ANT), .IN_W(RATE_W), .LVLS(ANT_W), .OUT_W(SUM_W)
  ) u_tree (
    .clk(clk), .rstN(rstN),
    .leaves(laneRate),
    .sum(total)
  );

endmodule

// File: rtl/tput_eval.sv
module tput_eval
  import tput_pkg::*;
#(
  parameter int NUM_ANT  = 4,   // power of two, at least 2
  parameter int NUM_UE   = 8,
  parameter int GAIN_W   = 8,
  parameter int THR_W    = 8,
  parameter int THR_FRAC = 2,
  parameter int RATE_W   = 8,
  parameter int NUM_LVL  = 4,
  parameter int TAG_W    = 4,
  localparam int ANT_W   = $clog2(NUM_ANT),
  localparam int UE_W    = $clog2(NUM_UE),
  localparam int LVL_W   = $clog2(NUM_LVL),
  localparam int IDX_W   = maxOf(ANT_W + UE_W, LVL_W),
  localparam int CFG_W   = maxOf(maxOf(GAIN_W, THR_W), RATE_W),
  localparam int SUM_W   = RATE_W + ANT_W,
  localparam int LAT     = 2 + ANT_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [1:0]              cfgSel,
  input  logic [IDX_W-1:0]        cfgIdx,
  input  logic [CFG_W-1:0]        cfgData,
  input  logic                    inValid,
  input  logic [TAG_W-1:0]        inTag,
  input  logic [NUM_ANT-1:0]      inActive,
  input  logic [NUM_ANT*UE_W-1:0] inUe,
  output logic                    outValid,
  output logic [TAG_W-1:0]        outTag,
  output logic [SUM_W-1:0]        outTotal
);

  ctlStrobe_t       strb;
  logic [SUM_W-1:0] total;

  tput_ctl #(.TAG_W(TAG_W), .LAT(LAT)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel),
    .inValid(inValid), .inTag(inTag),
    .strb(strb),
    .outValid(outValid), .outTag(outTag)
  );

  tput_dp #(
    .NUM_ANT(NUM_ANT), .NUM_UE(NUM_UE), .GAIN_W(GAIN_W), .THR_W(THR_W),
    .THR_FRAC(THR_FRAC), .RATE_W(RATE_W), .NUM_LVL(NUM_LVL),
    .ANT_W(ANT_W), .UE_W(UE_W), .LVL_W(LVL_W), .IDX_W(IDX_W),
    .CFG_W(CFG_W), .SUM_W(SUM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgIdx(cfgIdx), .cfgData(cfgData),
    .inActive(inActive), .inUe(inUe),
    .total(total)
  );

  assign outTotal = outValid ? total : '0;

endmodule

// File: rtl/tput_eval_chk.sv
module tput_eval_chk #(
  parameter int NUM_ANT = 4,
  parameter int RATE_W  = 8,
  parameter int TAG_W   = 4,
  parameter int SUM_W   = 10,
  parameter int LAT     = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [TAG_W-1:0]   inTag,
  input logic [NUM_ANT-1:0] inActive,
  input logic               outValid,
  input logic [TAG_W-1:0]   outTag,
  input logic [SUM_W-1:0]   outTotal
);

  // Edges seen since reset release, saturating at LAT
  int age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         age <= 0;
    else if (age < LAT) age <= age + 1;
  end

  // R1
  latency_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= LAT) |-> (outValid == $past(inValid, LAT)));

  // R1
  tag_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= LAT && outValid) |-> (outTag == $past(inTag, LAT)));

  // R4
  all_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= LAT && $past(inValid && (inActive == '0), LAT)) |-> (outTotal == '0));

  // R5
  lane_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= LAT && outValid) |->
      (int'(outTotal) <= $countones($past(inActive, LAT)) * ((1 << RATE_W) - 1)));

endmodule

bind tput_eval tput_eval_chk #(
  .NUM_ANT(NUM_ANT), .RATE_W(RATE_W), .TAG_W(TAG_W), .SUM_W(SUM_W), .LAT(LAT)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag),
  .inActive(inActive), .outValid(outValid), .outTag(outTag), .outTotal(outTotal)
);

// File: tb/sim_tput_eval.sv
module sim_tput_eval;

  localparam int NA   = 4;
  localparam int NU   = 8;
  localparam int UEW  = 3;
  localparam int NLVL = 4;
  localparam int FRAC = 2;
  localparam int LAT  = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgWe;
  logic [1:0] cfgSel;
  logic [4:0] cfgIdx;
  logic [7:0] cfgData;
  logic       inValid;
  logic [3:0] inTag;
  logic [NA-1:0] inActive;
  logic [NA*UEW-1:0] inUe;
  logic       outValid;
  logic [3:0] outTag;
  logic [9:0] outTotal;

  always #5 clk = ~clk;

  tput_eval u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .inValid(inValid), .inTag(inTag),
    .inActive(inActive), .inUe(inUe), .outValid(outValid),
    .outTag(outTag), .outTotal(outTotal)
  );

  int gM [NA][NU];
  int noiseM;
  int thrM [NLVL];
  int rateM [NLVL];

  int checks = 0, fails = 0, cyc = 0, tagCnt = 0;
  bit started = 0, done = 0;
  logic [31:0] seed = 32'h1234_5678;

  typedef struct {
    int    total;
    int    tag;
    int    due;
    string req;
  } exp_t;
  exp_t sb[$];
  exp_t mon;

  always @(posedge clk) cyc <= cyc + 1;

  // Independent model of R2..R5
  function automatic int modelTotal(input logic [NA-1:0] act, input logic [NA*UEW-1:0] ues);
    int sum = 0;
    for (int a = 0; a < NA; a++) begin
      if (act[a]) begin
        int u, sig, den, r;
        u   = int'(ues[a*UEW +: UEW]);
        sig = gM[a][u];
        den = noiseM;
        for (int b = 0; b < NA; b++)
          if (b != a && act[b]) den += gM[b][u];
        r = 0;
        for (int k = 0; k < NLVL; k++)
          if (sig * (1 << FRAC) >= thrM[k] * den) r = rateM[k];
        sum += r;
      end
    end
    return sum;
  endfunction

  task automatic nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
  endtask

  task automatic wrCfg(input logic [1:0] sel, input int idx, input int data);
    @(negedge clk);
    inValid = 1'b0;
    cfgWe   = 1'b1;
    cfgSel  = sel;
    cfgIdx  = idx[4:0];
    cfgData = data[7:0];
    @(negedge clk);
    cfgWe   = 1'b0;
  endtask

  // R6: gain index is antenna in bits [4:3], user in bits [2:0]
  task automatic setGain(input int a, input int u, input int v);
    wrCfg(2'd0, (a << UEW) | u, v);
    gM[a][u] = v;
  endtask
  task automatic setNoise(input int v);
    wrCfg(2'd1, 0, v);
    noiseM = v;
  endtask
  task automatic setThr(input int k, input int v);
    wrCfg(2'd2, k, v);
    thrM[k] = v;
  endtask
  task automatic setRate(input int k, input int v);
    wrCfg(2'd3, k, v);
    rateM[k] = v;
  endtask

  // Driver: presents one combination and pushes the expected result
  task automatic send(input logic [NA-1:0] act, input logic [NA*UEW-1:0] ues, input string req);
    exp_t e;
    @(negedge clk);
    inValid  = 1'b1;
    inActive = act;
    inUe     = ues;
    inTag    = tagCnt[3:0];
    e.total  = modelTotal(act, ues);
    e.tag    = tagCnt % 16;
    e.due    = cyc + LAT;
    e.req    = req;
    sb.push_back(e);
    tagCnt++;
  endtask

  // Idle cycles with junk on the data inputs (R1: ignored without inValid)
  task automatic idleN(input int n);
    repeat (n) begin
      @(negedge clk);
      nextRand();
      inValid  = 1'b0;
      inActive = seed[3:0];
      inUe     = seed[15:4];
      inTag    = seed[19:16];
    end
  endtask

  // Monitor: pops and compares each result
  always @(negedge clk) begin
    if (rstN && started) begin
      if (outValid) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R1: unexpected result total=%0d tag=%0d expected no result", outTotal, outTag);
        end else begin
          mon = sb.pop_front();
          if (int'(outTotal) != mon.total || int'(outTag) != mon.tag || cyc != mon.due) begin
            fails++;
            $display("FAIL %s: total=%0d tag=%0d cycle=%0d expected total=%0d tag=%0d cycle=%0d",
                     mon.req, outTotal, outTag, cyc, mon.total, mon.tag, mon.due);
          end
        end
      end else begin
        checks++;
        if (outTotal !== 10'd0) begin
          fails++;
          $display("FAIL R7: idle total=%0d expected 0", outTotal);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1: watchdog expired, pending=%0d expected 0", sb.size());
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgSel = '0; cfgIdx = '0; cfgData = '0;
    inValid = 1'b0; inTag = '0; inActive = '0; inUe = '0;
    for (int a = 0; a < NA; a++) for (int u = 0; u < NU; u++) gM[a][u] = 0;
    noiseM = 0;
    for (int k = 0; k < NLVL; k++) begin thrM[k] = 0; rateM[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7: reset state
    checks++;
    if (outValid !== 1'b0 || outTotal !== 10'd0) begin
      fails++;
      $display("FAIL R7: after reset valid=%0b total=%0d expected valid=0 total=0", outValid, outTotal);
    end
    started = 1;

    // R6: load tables through the write port
    setNoise(4);
    setThr(0, 2);  setThr(1, 8);  setThr(2, 24); setThr(3, 60);
    setRate(0, 12); setRate(1, 30); setRate(2, 55); setRate(3, 90);
    for (int a = 0; a < NA; a++)
      for (int u = 0; u < NU; u++)
        setGain(a, u, ((u % NA) == a) ? (200 + u) : ((a * 13 + u * 7) % 31));

    // R2: interference from other transmitting antennas, shared users
    send(4'b0001, {3'd0, 3'd0, 3'd0, 3'd0}, "R2");
    send(4'b0011, {3'd0, 3'd0, 3'd5, 3'd0}, "R2");
    send(4'b0011, {3'd0, 3'd0, 3'd0, 3'd0}, "R2");
    send(4'b1111, {3'd3, 3'd2, 3'd1, 3'd0}, "R2");
    send(4'b1111, {3'd7, 3'd6, 3'd5, 3'd4}, "R2");
    // R4: blank antennas add nothing
    send(4'b0000, {3'd3, 3'd2, 3'd1, 3'd0}, "R4");
    send(4'b0101, {3'd3, 3'd2, 3'd1, 3'd0}, "R4");
    send(4'b0111, {3'd3, 3'd2, 3'd1, 3'd0}, "R4");
    idleN(6);

    // R1: back-to-back pseudo-random stream
    for (int i = 0; i < 48; i++) begin
      nextRand();
      send(seed[3:0], seed[15:4], "R1");
    end
    idleN(8);

    // R3: exact threshold boundary (noise 3, level1 = 8 -> 24 = 6*4)
    setNoise(3);
    setGain(0, 0, 6);
    send(4'b0001, {3'd0, 3'd0, 3'd0, 3'd0}, "R3");
    setGain(0, 0, 5);
    send(4'b0001, {3'd0, 3'd0, 3'd0, 3'd0}, "R3");
    setGain(0, 0, 1);
    send(4'b0001, {3'd0, 3'd0, 3'd0, 3'd0}, "R3");
    idleN(6);

    // R5: every lane at the largest rate
    setNoise(0);
    setRate(3, 255);
    for (int u = 0; u < NA; u++)
      for (int b = 0; b < NA; b++)
        setGain(b, u, (b == u) ? 255 : 0);
    send(4'b1111, {3'd3, 3'd2, 3'd1, 3'd0}, "R5");
    send(4'b1011, {3'd3, 3'd2, 3'd1, 3'd0}, "R5");
    idleN(6);

    while (sb.size() != 0) @(negedge clk);
    idleN(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule